// File: doc/BRIEF.md
# Dual-Port Mailbox Register Bank

This block is a small shared register bank that lets a host processor and a management controller exchange short messages. Sixteen byte-wide data slots are visible from both sides. A write by the host into a slot raises a per-slot status flag on the controller side. That flag can raise the controller's interrupt if its enable bit is set.

A doorbell path carries a one-bit signal in each direction. The host rings the controller by setting a receive-pending flag. The controller acknowledges that flag with a write-one-to-clear access, and the same access unmasks its interrupt. In the other direction, the controller raises a send flag that the host sees on a dedicated output and in its own control register. The host clears that flag.

Both ports are plain synchronous register interfaces on one clock. Each has a byte address, a write strobe, 32-bit write data and 32-bit read data. Reads are combinational from the current address. Writes take effect at the next rising edge.

Top module: `mbx_regbank`

## Requirements
- R1: After a synchronous active-low reset, every data byte, status bit, enable bit, the receive-pending flag, the mask bit and the send flag are zero, and `ctl_irq` and `hst_doorbell` are low.
- R2: Data slot n is at byte address 4·n (n = 0..15) on both ports, and address bits [1:0] are ignored. Either port may write a slot, and both ports read the same value. Bits [31:8] of every read are zero, and write bits [31:8] are ignored. A host read of any address other than a data slot or 0x4C returns zero.
- R3: A host write to slot n sets status bit n. Status bits 0..7 read at controller address 0x40 (bit i = slot i), and bits 8..15 read at 0x44 (bit i = slot 8+i). A controller write to a slot sets no status bit.
- R4: The controller clears status bits by writing ones to 0x40 or 0x44. Zero bits in that write have no effect. A host write that sets a bit in the same cycle as its clear leaves the bit set.
- R5: Interrupt enables are read/write at controller address 0x50 (slots 0..7) and 0x54 (slots 8..15). `ctl_irq` is high while any status bit and its enable bit are both set.
- R6: A host write to 0x4C with bit 0 set sets the receive-pending flag, which reads as bit 7 of controller address 0x48 and bit 0 of host address 0x4C. `ctl_irq` is high while that flag is set and the mask bit is clear.
- R7: A controller write to 0x48 with bit 1 set sets the mask bit, which reads as bit 1 of 0x48. The mask stops the receive-pending flag from raising `ctl_irq`, but the flag still sets and still reads back.
- R8: A controller write to 0x48 with bit 7 set clears the receive-pending flag. In the same access it also clears the mask unless bit 1 is set in that write. Zero bits written to 0x48 have no effect.
- R9: A controller write to 0x48 with bit 0 set sets the send flag. The send flag drives `hst_doorbell` and reads as bit 0 of 0x48 and bit 7 of host address 0x4C. The host clears it by writing 0x4C with bit 7 set. If a set and a clear happen in the same cycle, the set wins.
- R10: If both ports write the same slot in the same cycle, the slot keeps the host's byte.
- R11: Reads are combinational. The result of a write is visible on reads from the cycle after its clock edge, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_addr | input | 8 | Controller-side byte address |
| ctl_we | input | 1 | Controller-side write strobe |
| ctl_wdata | input | 32 | Controller-side write data (low byte used) |
| ctl_rdata | output | 32 | Controller-side read data |
| hst_addr | input | 8 | Host-side byte address |
| hst_we | input | 1 | Host-side write strobe |
| hst_wdata | input | 32 | Host-side write data (low byte used) |
| hst_rdata | output | 32 | Host-side read data |
| ctl_irq | output | 1 | Interrupt request to the controller |
| hst_doorbell | output | 1 | Send flag presented to the host |

## Verification
The embedded properties check every cycle that:
- a host slot write always leaves its status bit set;
- a set status bit stays set unless a controller clear hits it;
- the host doorbell always lands in the receive-pending flag;
- the mask never drops that flag;
- an acknowledge clears the flag and unmasks;
- a controller send always reaches the host;
- a same-cycle collision keeps the host byte.

Only the bench's scenarios can show the rest:
- the address map and the four-byte stride;
- reserved bytes reading zero;
- the interrupt turning on and off as enables, status and mask change;
- the ordering of reads against the write edge.

// File: rtl/mbx_pkg.sv
// Package: shared constants and the decoded-strobe type for the mailbox bank.
// Assumes word-aligned byte addressing; word index is address bits [AW-1:2].
package mbx_pkg;
    localparam int NREG   = 16;              // data slots
    localparam int BW     = 8;               // bits per slot
    localparam int BANK   = 8;               // slots per status/enable register
    localparam int NBANK  = NREG / BANK;
    localparam int AW     = 8;               // byte address width
    localparam int DW     = 32;              // bus data width
    localparam int WW     = AW - 2;          // word index width
    // word indices of the control registers
    localparam int W_STAT = NREG;            // 0x40, 0x44
    localparam int W_CTL  = NREG + NBANK;    // 0x48
    localparam int W_HCTL = W_CTL + 1;       // 0x4C
    localparam int W_EN   = W_HCTL + 1;      // 0x50, 0x54
    // bit positions inside the two control registers
    localparam int CB_RECV = 7;
    localparam int CB_MASK = 1;
    localparam int CB_SEND = 0;
    localparam int HB_BELL = 0;
    localparam int HB_SEND = 7;

    typedef struct packed {
        logic [NREG-1:0]  data;
        logic [NBANK-1:0] stat;
        logic [NBANK-1:0] en;
        logic             ctl;
        logic             hctl;
    } sel_t;
endpackage

// File: rtl/mbx_decode.sv
// Module: address decoder for one port. Produces one strobe per register,
// gated with the write enable, plus the ungated hit vector for read muxing.
// Assumes address bits [1:0] carry no meaning.
module mbx_decode
    import mbx_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          we,
    output sel_t          hit,
    output sel_t          wsel
);
    logic [WW-1:0] widx;
    assign widx = addr[AW-1:2];

    // decode the word index into per-register hits
    always_comb begin
        hit = '0;
        for (int n = 0; n < NREG; n++)
            hit.data[n] = (widx == WW'(n));
        for (int b = 0; b < NBANK; b++) begin
            hit.stat[b] = (widx == WW'(W_STAT + b));
            hit.en[b]   = (widx == WW'(W_EN + b));
        end
        hit.ctl  = (widx == WW'(W_CTL));
        hit.hctl = (widx == WW'(W_HCTL));
    end

    // qualify hits with the write strobe
    assign wsel = we ? hit : '0;
endmodule

// File: rtl/mbx_data_bank.sv
// Module: the sixteen shared data bytes. Either port may write a slot;
// when both write the same slot in one cycle the host byte is kept.
// Assumes strobes are already decoded and gated with write enable.
module mbx_data_bank
    import mbx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREG-1:0]          c_wr,
    input  logic [NREG-1:0]          h_wr,
    input  logic [BW-1:0]            c_byte,
    input  logic [BW-1:0]            h_byte,
    output logic [NREG-1:0][BW-1:0]  data
);
    for (genvar n = 0; n < NREG; n++) begin : g_slot
        // one slot register, host write has priority
        always_ff @(posedge clk) begin
            if (!rst_n)        data[n] <= '0;
            else if (h_wr[n])  data[n] <= h_byte;
            else if (c_wr[n])  data[n] <= c_byte;
        end

        // R10: collision keeps the host byte
        p_host_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (h_wr[n] && c_wr[n]) |=> (data[n] == $past(h_byte)));
    end
endmodule

// File: rtl/mbx_flags.sv
// Module: status, enable and doorbell flags plus the controller interrupt.
// Status bits are set by host slot writes and cleared write-one-to-clear by
// the controller; the receive flag and mask follow the acknowledge rules.
// Assumes strobes are decoded and gated with write enable.
module mbx_flags
    import mbx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  sel_t            c_w,
    input  sel_t            h_w,
    input  logic [BW-1:0]   c_byte,
    input  logic [BW-1:0]   h_byte,
    output logic [NREG-1:0] stat,
    output logic [NREG-1:0] en,
    output logic            recv,
    output logic            mask,
    output logic            send,
    output logic            irq
);
    logic [NREG-1:0] stat_clr;
    logic            ack, mask_set, send_set, bell, send_clr;

    assign ack      = c_w.ctl  && c_byte[CB_RECV];
    assign mask_set = c_w.ctl  && c_byte[CB_MASK];
    assign send_set = c_w.ctl  && c_byte[CB_SEND];
    assign bell     = h_w.hctl && h_byte[HB_BELL];
    assign send_clr = h_w.hctl && h_byte[HB_SEND];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // per-bank clear vector from a controller write-one-to-clear
        assign stat_clr[b*BANK +: BANK] = c_w.stat[b] ? c_byte : '0;

        // per-bank enable register
        always_ff @(posedge clk) begin
            if (!rst_n)         en[b*BANK +: BANK] <= '0;
            else if (c_w.en[b]) en[b*BANK +: BANK] <= c_byte;
        end
    end

    // status: clear requested bits, then set from host slot writes
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~stat_clr) | h_w.data;
    end

    // receive-pending flag: host rings, controller acknowledges
    always_ff @(posedge clk) begin
        if (!rst_n)    recv <= 1'b0;
        else if (bell) recv <= 1'b1;
        else if (ack)  recv <= 1'b0;
    end

    // mask: set by its own bit, released by an acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)        mask <= 1'b0;
        else if (mask_set) mask <= 1'b1;
        else if (ack)      mask <= 1'b0;
    end

    // send flag toward the host, set wins over the host's clear
    always_ff @(posedge clk) begin
        if (!rst_n)        send <= 1'b0;
        else if (send_set) send <= 1'b1;
        else if (send_clr) send <= 1'b0;
    end

    // controller interrupt from doorbell and enabled status bits
    assign irq = (recv && !mask) || |(stat & en);

    for (genvar n = 0; n < NREG; n++) begin : g_chk
        // R3: host slot write always leaves its status bit set
        p_stat_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
            h_w.data[n] |=> stat[n]);
        // R4: a set bit survives unless a clear targets it
        p_stat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[n] && !stat_clr[n]) |=> stat[n]);
    end

    // R6: host doorbell lands in the receive flag
    p_bell_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bell |=> recv);
    // R7: masking never drops a pending flag
    p_mask_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (recv && mask_set && !ack) |=> (recv && mask));
    // R8: acknowledge clears the flag and unmasks in one access
    p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !mask_set && !bell) |=> (!recv && !mask));
    // R9: a controller send always reaches the host
    p_send_r9: assert property (@(posedge clk) disable iff (!rst_n)
        send_set |=> send);
endmodule

// File: rtl/mbx_regbank.sv
// Module: top of the dual-port mailbox. Decodes both ports, holds the data
// slots and flags, and builds the two combinational read buses.
// Assumes one shared clock and synchronous active-low reset.
module mbx_regbank
    import mbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    ctl_addr,
    input  logic          ctl_we,
    input  logic [31:0]   ctl_wdata,
    output logic [31:0]   ctl_rdata,
    input  logic [7:0]    hst_addr,
    input  logic          hst_we,
    input  logic [31:0]   hst_wdata,
    output logic [31:0]   hst_rdata,
    output logic          ctl_irq,
    output logic          hst_doorbell
);
    sel_t c_hit, c_w, h_hit, h_w;
    logic [NREG-1:0][BW-1:0] data;
    logic [NREG-1:0] stat, en;
    logic recv, mask, send;
    logic [BW-1:0] c_rd, h_rd, ctl_reg, hctl_reg;

    mbx_decode u_cdec (.addr(ctl_addr), .we(ctl_we), .hit(c_hit), .wsel(c_w));
    mbx_decode u_hdec (.addr(hst_addr), .we(hst_we), .hit(h_hit), .wsel(h_w));

    mbx_data_bank u_data (
        .clk(clk), .rst_n(rst_n),
        .c_wr(c_w.data), .h_wr(h_w.data),
        .c_byte(ctl_wdata[BW-1:0]), .h_byte(hst_wdata[BW-1:0]),
        .data(data)
    );

    mbx_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .c_w(c_w), .h_w(h_w),
        .c_byte(ctl_wdata[BW-1:0]), .h_byte(hst_wdata[BW-1:0]),
        .stat(stat), .en(en), .recv(recv), .mask(mask), .send(send),
        .irq(ctl_irq)
    );

    // assemble the two control-register views
    always_comb begin
        ctl_reg = '0;
        ctl_reg[CB_RECV] = recv;
        ctl_reg[CB_MASK] = mask;
        ctl_reg[CB_SEND] = send;
        hctl_reg = '0;
        hctl_reg[HB_SEND] = send;
        hctl_reg[HB_BELL] = recv;
    end

    // controller read mux: slots, status, enables, both control registers
    always_comb begin
        c_rd = '0;
        for (int n = 0; n < NREG; n++)
            if (c_hit.data[n]) c_rd = data[n];
        for (int b = 0; b < NBANK; b++) begin
            if (c_hit.stat[b]) c_rd = stat[b*BANK +: BANK];
            if (c_hit.en[b])   c_rd = en[b*BANK +: BANK];
        end
        if (c_hit.ctl)  c_rd = ctl_reg;
        if (c_hit.hctl) c_rd = hctl_reg;
    end

    // host read mux: slots and the host control register only
    always_comb begin
        h_rd = '0;
        for (int n = 0; n < NREG; n++)
            if (h_hit.data[n]) h_rd = data[n];
        if (h_hit.hctl) h_rd = hctl_reg;
    end

    assign ctl_rdata    = {{(DW-BW){1'b0}}, c_rd};
    assign hst_rdata    = {{(DW-BW){1'b0}}, h_rd};
    assign hst_doorbell = send;
endmodule

// File: tb/mbx_regbank_tb_top.sv
`timescale 1ns/1ps
module mbx_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ctl_addr = '0, hst_addr = '0;
    logic        ctl_we = 1'b0, hst_we = 1'b0;
    logic [31:0] ctl_wdata = '0, hst_wdata = '0;
    logic [31:0] ctl_rdata, hst_rdata;
    logic        ctl_irq, hst_doorbell;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mbx_regbank dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_addr(ctl_addr), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .hst_addr(hst_addr), .hst_we(hst_we), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .ctl_irq(ctl_irq), .hst_doorbell(hst_doorbell)
    );

    typedef struct packed {
        bit        wen;
        bit        wside;   // 0 controller, 1 host
        bit [7:0]  waddr;
        bit [31:0] wdata;
        bit        rside;
        bit [7:0]  raddr;
        bit [31:0] rexp;
        bit        irq;
        bit        db;
        bit [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,8'h00,32'h000000A5,1'b0,8'h00,32'hA5,1'b0,1'b0,4'd2},  // R2 ctl slot write
        '{1'b1,1'b1,8'h0C,32'h0000003C,1'b0,8'h40,32'h08,1'b0,1'b0,4'd3},  // R3 host write sets bit 3
        '{1'b0,1'b0,8'h00,32'h00000000,1'b1,8'h40,32'h00,1'b0,1'b0,4'd2},  // R2 host unmapped read
        '{1'b1,1'b0,8'h50,32'h00000008,1'b0,8'h50,32'h08,1'b1,1'b0,4'd5},  // R5 enable -> irq
        '{1'b1,1'b0,8'h40,32'h00000000,1'b0,8'h40,32'h08,1'b1,1'b0,4'd4},  // R4 zero clears nothing
        '{1'b1,1'b0,8'h40,32'h000000FF,1'b0,8'h40,32'h00,1'b0,1'b0,4'd4},  // R4 clear all
        '{1'b1,1'b1,8'h3C,32'h00000077,1'b0,8'h44,32'h80,1'b0,1'b0,4'd3},  // R3 upper bank
        '{1'b1,1'b0,8'h54,32'h00000080,1'b0,8'h54,32'h80,1'b1,1'b0,4'd5},  // R5 upper enable
        '{1'b1,1'b0,8'h44,32'h00000080,1'b0,8'h44,32'h00,1'b0,1'b0,4'd4},  // R4 upper clear
        '{1'b1,1'b1,8'h4C,32'h00000001,1'b0,8'h48,32'h80,1'b1,1'b0,4'd6},  // R6 host doorbell
        '{1'b1,1'b0,8'h48,32'h00000002,1'b0,8'h48,32'h82,1'b0,1'b0,4'd7},  // R7 mask
        '{1'b1,1'b0,8'h48,32'h00000080,1'b0,8'h48,32'h00,1'b0,1'b0,4'd8},  // R8 ack + unmask
        '{1'b1,1'b0,8'h48,32'h00000001,1'b1,8'h4C,32'h80,1'b0,1'b1,4'd9},  // R9 send
        '{1'b1,1'b1,8'h4C,32'h00000080,1'b1,8'h4C,32'h00,1'b0,1'b0,4'd9},  // R9 host clears
        '{1'b1,1'b0,8'h08,32'hFFFFFF12,1'b0,8'h08,32'h12,1'b0,1'b0,4'd2},  // R2 reserved bytes
        '{1'b0,1'b0,8'h00,32'h00000000,1'b1,8'h00,32'hA5,1'b0,1'b0,4'd2}   // R2 host sees ctl data
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input bit side, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (side) begin hst_addr = a; hst_wdata = d; hst_we = 1'b1; end
        else      begin ctl_addr = a; ctl_wdata = d; ctl_we = 1'b1; end
        @(negedge clk);
        hst_we = 1'b0; ctl_we = 1'b0;
    endtask

    task automatic wr2(input logic [7:0] ca, input logic [31:0] cd,
                       input logic [7:0] ha, input logic [31:0] hd);
        @(negedge clk);
        ctl_addr = ca; ctl_wdata = cd; ctl_we = 1'b1;
        hst_addr = ha; hst_wdata = hd; hst_we = 1'b1;
        @(negedge clk);
        hst_we = 1'b0; ctl_we = 1'b0;
    endtask

    task automatic rd(input bit side, input logic [7:0] a, output logic [31:0] v);
        if (side) hst_addr = a; else ctl_addr = a;
        #1;
        v = side ? hst_rdata : ctl_rdata;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(1'b0, 8'h48, v); chk("R1 ctl reg after reset", v, 32'h0);
        rd(1'b0, 8'h00, v); chk("R1 slot 0 after reset", v, 32'h0);
        chk("R1 irq/doorbell after reset", {30'b0, ctl_irq, hst_doorbell}, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wen) wr(VEC[i].wside, VEC[i].waddr, VEC[i].wdata);
            else @(negedge clk);
            rd(VEC[i].rside, VEC[i].raddr, v);
            chk($sformatf("R%0d vector %0d read", VEC[i].req, i), v, VEC[i].rexp);
            chk($sformatf("R%0d vector %0d irq/doorbell", VEC[i].req, i),
                {30'b0, ctl_irq, hst_doorbell}, {30'b0, VEC[i].irq, VEC[i].db});
        end

        // R10 same-slot collision keeps host byte; R3 status set
        wr2(8'h14, 32'h11, 8'h14, 32'h22);
        rd(1'b0, 8'h14, v); chk("R10 collision slot 5", v, 32'h22);
        rd(1'b0, 8'h40, v); chk("R3 collision sets status 5", v, 32'h20);

        // R4 host set beats same-cycle clear
        wr2(8'h40, 32'h24, 8'h08, 32'h5A);
        rd(1'b0, 8'h40, v); chk("R4 set wins over clear", v, 32'h04);
        rd(1'b0, 8'h08, v); chk("R2 host slot 2 write", v, 32'h5A);

        // R7 doorbell while masked: flag readable, irq low
        wr(1'b0, 8'h48, 32'h02);
        wr(1'b1, 8'h4C, 32'h01);
        rd(1'b0, 8'h48, v); chk("R7 masked pending read", v, 32'h82);
        chk("R7 masked irq", {31'b0, ctl_irq}, 32'h0);

        // R8 zero write to control register has no effect
        wr(1'b0, 8'h48, 32'h00);
        rd(1'b0, 8'h48, v); chk("R8 zero write ignored", v, 32'h82);
        wr(1'b0, 8'h48, 32'h80);
        rd(1'b0, 8'h48, v); chk("R8 ack clears and unmasks", v, 32'h00);

        // R9 send set beats host clear in the same cycle
        wr2(8'h48, 32'h01, 8'h4C, 32'h80);
        rd(1'b1, 8'h4C, v); chk("R9 set wins over clear", v, 32'h80);
        chk("R9 doorbell output", {31'b0, hst_doorbell}, 32'h1);

        // R11 write not visible before the edge, visible after
        @(negedge clk);
        ctl_addr = 8'h04; ctl_wdata = 32'h66; ctl_we = 1'b1;
        #1; chk("R11 before edge", ctl_rdata, 32'h00);
        @(negedge clk);
        ctl_we = 1'b0;
        #1; chk("R11 after edge", ctl_rdata, 32'h66);

        // R1 reset in mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(1'b0, 8'h04, v); chk("R1 slot 1 after reset", v, 32'h0);
        rd(1'b0, 8'h50, v); chk("R1 enables after reset", v, 32'h0);
        rd(1'b0, 8'h48, v); chk("R1 ctl reg after mid reset", v, 32'h0);
        chk("R1 outputs after mid reset", {30'b0, ctl_irq, hst_doorbell}, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule